// File: doc/BRIEF.md
# Auto-Increment Read Bus Master

This block performs reads of 4, 32 or 64 bytes on a simple memory request/response bus for a processor-side control port. The processor sets a transfer size code and an auto flag with a configuration strobe. It then writes a read address, either all 48 bits or only the low 32 bits. Each accepted address write queues one read command. The command goes out on a valid/ready request channel. The returning beats are gathered into a one-entry data buffer, which is presented on a valid/ready read stream.

With the auto flag set, every pop from the read stream launches the next read at the previous address plus the transfer size, so software can stream through memory. A status vector reports busy, command held, data held and read in flight. A command stays held until its final beat has been captured. The in-flight bit tells software when auto mode can be switched off safely.

Back-pressure rules are as follows. On the request channel, `m_req_valid` holds with a stable address and length until `m_req_ready`. On the read stream, `rd_valid` and `rd_data` hold until `rd_ready`. A pop is a cycle with both `rd_valid` and `rd_ready` high. The response channel has no ready signal. Beats are accepted from the cycle after the request handshake. A configuration write takes effect in the cycle after its strobe.

Top module: `rd_prefetch_master`

## Requirements
- R1: `cfg_size` code 0 selects 4 bytes (`m_req_len`=0), code 2 selects 32 bytes (`m_req_len`=7), and code 3 selects 64 bytes (`m_req_len`=15). Code 1 is reserved. One beat is 4 bytes and `m_req_len` is the beat count minus one.
- R2: An address write with `addr_full`=1 loads all 48 bits. With `addr_full`=0 it loads bits 31:0 and keeps the held bits 47:32.
- R3: An accepted address write with auto off issues exactly one request at the held address. In `rd_data`, lane k (bits 32k+31:32k) carries the k-th response beat, and the lanes beyond the transfer read zero.
- R4: With auto on, each pop issues one new request. Its address is the previous address plus 0x20 (32-byte size) or 0x40 (64-byte size), and the carry runs across all 48 bits.
- R5: If auto is cleared while a read is in flight, that read still completes and is presented, and no further request follows.
- R6: `rd_status[1]` (command held) is set from the cycle after an accepted address write or auto pop until the cycle after the final beat. `rd_status[3]` (in flight) is set from the cycle after the request handshake until the cycle after the final beat.
- R7: `rd_status[2]` equals `rd_valid`. It rises the cycle after the final beat and falls the cycle after the pop. `rd_status[0]` is the OR of bits 1 and 2. All status bits are zero after reset.
- R8: An address write is rejected in two cases: the held size code is 1, or auto is on with size code 0. A rejected write pulses `cmd_err` for exactly one cycle, issues no request and leaves the status unchanged.
- R9: An address write while `rd_status[1]` or `rd_status[2]` is set pulses `cmd_err` and is dropped, and the buffered data is left intact.
- R10: `m_req_valid` holds with a stable `m_req_addr` until `m_req_ready` is seen. `rd_valid` and `rd_data` hold until `rd_ready` is seen.
- R11: Response beats that arrive while no read is in flight are ignored and do not set `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Strobe that loads the auto flag and size code |
| cfg_auto | input | 1 | Auto mode enable |
| cfg_size | input | 2 | Transfer size code |
| addr_wr | input | 1 | Address write strobe; queues a read |
| addr_full | input | 1 | 1: load 48 bits, 0: load low 32 bits |
| addr_in | input | 48 | Read address |
| rd_valid | output | 1 | Read data available |
| rd_ready | input | 1 | Consumer takes read data |
| rd_data | output | 512 | Assembled read data, beat k in lane k |
| rd_status | output | 4 | {in flight, data held, command held, busy} |
| cmd_err | output | 1 | One-cycle pulse for a rejected address write |
| m_req_valid | output | 1 | Bus read request valid |
| m_req_ready | input | 1 | Bus accepts request |
| m_req_addr | output | 48 | Request byte address |
| m_req_len | output | 4 | Beats minus one |
| m_rsp_valid | input | 1 | Response beat valid |
| m_rsp_data | input | 32 | Response beat data |
| m_rsp_last | input | 1 | Final beat of the response |

## Verification
The main function is exercised in several ways, each of which separates a different kind of fault:
- Single reads of each size separate the beat-count and lane-placement errors.
- A low-half address write after a full write shows whether the upper 16 bits survive.
- An auto run that starts just below a 32-bit boundary exposes an increment that does not carry into the upper field.
- Clearing auto while beats are still arriving, and then watching for silence, separates "finish and stop" from both early cancellation and a runaway prefetch.
- Stalled request acceptance, gapped beats, a held-off consumer and stray beats on an idle bus each probe the hold rules and the in-flight gating.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;
  typedef enum logic [1:0] {
    SZ_4B  = 2'd0,
    SZ_RSV = 2'd1,
    SZ_32B = 2'd2,
    SZ_64B = 2'd3
  } rd_size_e;

  function automatic int unsigned size_bytes(input rd_size_e s);
    case (s)
      SZ_32B:  return 32;
      SZ_64B:  return 64;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/rdpf_cmd_ctrl.sv
module rdpf_cmd_ctrl
  import rdpf_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LO_W       = 32,
  parameter int BEAT_BYTES = 4,
  parameter int LEN_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_i,
  input  logic              cfg_auto_i,
  input  logic [1:0]        cfg_size_i,
  input  logic              addr_wr_i,
  input  logic              addr_full_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pop_i,
  input  logic              data_occ_i,
  input  logic              done_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              cmd_occ_o,
  output logic              inflight_o,
  output logic              err_o
);
  logic              auto_q;
  rd_size_e          size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              cmd_occ_q, sent_q, err_q;

  logic              size_bad, blocked, man_load, man_err, auto_load;
  logic [ADDR_W-1:0] step_w;
  logic [LEN_W-1:0]  len_w;

  // Size legality is judged against the held configuration.
  assign size_bad  = (size_q == SZ_RSV) || (auto_q && size_q == SZ_4B);
  assign blocked   = cmd_occ_q || data_occ_i;
  assign man_load  = addr_wr_i && !size_bad && !blocked;
  assign man_err   = addr_wr_i && (size_bad || blocked);
  assign auto_load = pop_i && auto_q && !size_bad;

  assign step_w = ADDR_W'(size_bytes(size_q));
  assign len_w  = LEN_W'(size_bytes(size_q) / BEAT_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q    <= 1'b0;
      size_q    <= SZ_4B;
      addr_q    <= '0;
      len_q     <= '0;
      cmd_occ_q <= 1'b0;
      sent_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= man_err;
      if (cfg_wr_i) begin
        auto_q <= cfg_auto_i;
        size_q <= rd_size_e'(cfg_size_i);
      end
      if (man_load) begin
        if (addr_full_i) addr_q <= addr_i;
        else             addr_q[LO_W-1:0] <= addr_i[LO_W-1:0];
      end else if (auto_load) begin
        addr_q <= addr_q + step_w;
      end
      if (man_load || auto_load) begin
        cmd_occ_q <= 1'b1;
        sent_q    <= 1'b0;
        len_q     <= len_w;
      end else begin
        if (req_valid_o && req_ready_i) sent_q <= 1'b1;
        if (done_i) begin
          cmd_occ_q <= 1'b0;
          sent_q    <= 1'b0;
        end
      end
    end
  end

  assign req_valid_o = cmd_occ_q && !sent_q;
  assign req_addr_o  = addr_q;
  assign req_len_o   = len_q;
  assign cmd_occ_o   = cmd_occ_q;
  assign inflight_o  = cmd_occ_q && sent_q;
  assign err_o       = err_q;

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));

  p_err_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($stable(addr_q) || $past(pop_i)));

  p_done_clears_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !cmd_occ_q);
endmodule

// File: rtl/rdpf_beat_collect.sv
module rdpf_beat_collect #(
  parameter int BEAT_W    = 32,
  parameter int MAX_BEATS = 16,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = BEAT_W * MAX_BEATS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              collect_i,
  input  logic              rsp_valid_i,
  input  logic [BEAT_W-1:0] rsp_data_i,
  input  logic              rsp_last_i,
  output logic              done_o,
  output logic              data_occ_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              pop_o
);
  logic [IDX_W-1:0] idx_q;
  logic             occ_q;
  logic             take;

  // Beats count only while a request is in flight and the buffer is free.
  assign take   = rsp_valid_i && collect_i && !occ_q;
  assign done_o = take && rsp_last_i;
  assign pop_o  = occ_q && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      occ_q <= 1'b0;
    end else begin
      if (take) begin
        if (rsp_last_i)                        idx_q <= '0;
        else if (idx_q != IDX_W'(MAX_BEATS-1)) idx_q <= idx_q + 1'b1;
      end
      if (done_o)     occ_q <= 1'b1;
      else if (pop_o) occ_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_lane
    logic [BEAT_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else if (take) begin
        if (idx_q == IDX_W'(g))  lane_q <= rsp_data_i;
        else if (idx_q == '0)    lane_q <= '0;  // first beat wipes the tail
      end
    end
    assign out_data_o[g*BEAT_W +: BEAT_W] = lane_q;
  end

  assign data_occ_o  = occ_q;
  assign out_valid_o = occ_q;

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_occ_rise_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(occ_q) |-> $past(rsp_valid_i && rsp_last_i && collect_i));
endmodule

// File: rtl/rdpf_status.sv
module rdpf_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_occ_i,
  input  logic       data_occ_i,
  input  logic       inflight_i,
  output logic [3:0] status_o
);
  assign status_o = {inflight_i, data_occ_i, cmd_occ_i, cmd_occ_i | data_occ_i};

  p_inflight_needs_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_i |-> cmd_occ_i);

  p_cmd_data_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_occ_i && data_occ_i));
endmodule

// File: rtl/rd_prefetch_master.sv
module rd_prefetch_master #(
  parameter int ADDR_W     = 48,
  parameter int LO_W       = 32,
  parameter int BEAT_BYTES = 4,
  parameter int MAX_BYTES  = 64,
  localparam int BEAT_W    = BEAT_BYTES * 8,
  localparam int MAX_BEATS = MAX_BYTES / BEAT_BYTES,
  localparam int LEN_W     = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1,
  localparam int DATA_W    = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_auto,
  input  logic [1:0]        cfg_size,
  input  logic              addr_wr,
  input  logic              addr_full,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        rd_status,
  output logic              cmd_err,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [LEN_W-1:0]  m_req_len,
  input  logic              m_rsp_valid,
  input  logic [BEAT_W-1:0] m_rsp_data,
  input  logic              m_rsp_last
);
  logic pop, done, data_occ, cmd_occ, inflight;

  rdpf_cmd_ctrl #(
    .ADDR_W(ADDR_W), .LO_W(LO_W), .BEAT_BYTES(BEAT_BYTES), .LEN_W(LEN_W)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_auto_i(cfg_auto), .cfg_size_i(cfg_size),
    .addr_wr_i(addr_wr), .addr_full_i(addr_full), .addr_i(addr_in),
    .pop_i(pop), .data_occ_i(data_occ), .done_i(done),
    .req_valid_o(m_req_valid), .req_ready_i(m_req_ready),
    .req_addr_o(m_req_addr), .req_len_o(m_req_len),
    .cmd_occ_o(cmd_occ), .inflight_o(inflight), .err_o(cmd_err)
  );

  rdpf_beat_collect #(
    .BEAT_W(BEAT_W), .MAX_BEATS(MAX_BEATS), .IDX_W(LEN_W), .DATA_W(DATA_W)
  ) u_collect (
    .clk(clk), .rst_n(rst_n),
    .collect_i(inflight),
    .rsp_valid_i(m_rsp_valid), .rsp_data_i(m_rsp_data), .rsp_last_i(m_rsp_last),
    .done_o(done), .data_occ_o(data_occ),
    .out_valid_o(rd_valid), .out_ready_i(rd_ready), .out_data_o(rd_data),
    .pop_o(pop)
  );

  rdpf_status u_status (
    .clk(clk), .rst_n(rst_n),
    .cmd_occ_i(cmd_occ), .data_occ_i(data_occ), .inflight_i(inflight),
    .status_o(rd_status)
  );
endmodule

// File: tb/tb_rd_prefetch_master.sv
`timescale 1ns/1ps
module tb_rd_prefetch_master;
  logic         clk = 0;
  logic         rst_n;
  logic         cfg_wr, cfg_auto, addr_wr, addr_full, rd_ready, m_req_ready;
  logic [1:0]   cfg_size;
  logic [47:0]  addr_in, m_req_addr;
  logic         rd_valid, cmd_err, m_req_valid, m_rsp_valid, m_rsp_last;
  logic [511:0] rd_data;
  logic [3:0]   rd_status, m_req_len;
  logic [31:0]  m_rsp_data;

  int checks = 0, failures = 0, req_seen = 0, req_stall = 2, beat_gap = 0, n0;
  bit last_err, stray_go = 0;
  string req_tag = "R3 request";
  logic [51:0] exp_req_q[$];
  logic [55:0] exp_dat_q[$];

  always #5 clk = ~clk;

  rd_prefetch_master dut (.*);

  function automatic logic [31:0] memw(input logic [47:0] a);
    return a[31:0] ^ {a[47:32], 16'hC3A5};
  endfunction

  function automatic logic [511:0] exp_data(input logic [47:0] a, input int nb);
    logic [511:0] v = '0;
    for (int k = 0; k < nb / 4; k++) v[k*32 +: 32] = memw(a + 48'(4 * k));
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_rd(input logic [47:0] a, input int nb);
    exp_req_q.push_back({4'(nb / 4 - 1), a});
    exp_dat_q.push_back({8'(nb), a});
  endtask

  task automatic cfg(input bit au, input logic [1:0] sz);
    cfg_wr = 1; cfg_auto = au; cfg_size = sz;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic waddr(input bit full, input logic [47:0] a);
    addr_wr = 1; addr_full = full; addr_in = a;
    @(negedge clk);
    addr_wr = 0;
    last_err = cmd_err;
  endtask

  task automatic pop_chk(input string req);
    logic [55:0] e;
    logic [511:0] ev;
    while (!rd_valid) @(negedge clk);
    if (exp_dat_q.size() == 0) chk(0, req, rd_data, 0);
    else begin
      e  = exp_dat_q.pop_front();
      ev = exp_data(e[47:0], int'(e[55:48]));
      chk(rd_data == ev, req, rd_data, ev);
    end
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  // Bus responder and request scoreboard monitor.
  initial begin
    logic [47:0] a0, a;
    logic [3:0]  l;
    logic [51:0] er;
    m_req_ready = 0; m_rsp_valid = 0; m_rsp_last = 0; m_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (stray_go) begin
        m_rsp_valid = 1; m_rsp_last = 1; m_rsp_data = 32'hDEAD_BEEF;
        @(negedge clk);
        m_rsp_valid = 0; m_rsp_last = 0; stray_go = 0;
      end else if (m_req_valid) begin
        a0 = m_req_addr;
        for (int s = 0; s < req_stall; s++) @(negedge clk);
        chk(m_req_valid && m_req_addr == a0, "R10 request held", m_req_addr, a0);
        m_req_ready = 1; a = m_req_addr; l = m_req_len;
        if (exp_req_q.size() == 0) chk(0, "R3 unexpected request", a, 0);
        else begin
          er = exp_req_q.pop_front();
          chk(a == er[47:0], req_tag, a, er[47:0]);
          chk(l == er[51:48], "R1 beat count", l, er[51:48]);
        end
        req_seen++;
        @(negedge clk);
        m_req_ready = 0;
        for (int k = 0; k <= int'(l); k++) begin
          m_rsp_valid = 1; m_rsp_data = memw(a + 48'(4 * k)); m_rsp_last = (k == int'(l));
          @(negedge clk);
          m_rsp_valid = 0; m_rsp_last = 0;
          for (int g = 0; g < beat_gap; g++) @(negedge clk);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_auto = 0; cfg_size = 0; addr_wr = 0; addr_full = 0;
    addr_in = '0; rd_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_status == 0 && !rd_valid && !m_req_valid && !cmd_err, "R7 reset state",
        {rd_status, rd_valid, m_req_valid, cmd_err}, 0);

    // R1 and R6/R7: single 4-byte read, status walk
    req_tag = "R1 4-byte address";
    cfg(0, 2'd0);
    n0 = req_seen;
    expect_rd(48'h1234_0000_0100, 4);
    waddr(1, 48'h1234_0000_0100);
    chk(!last_err, "R8 no error on legal write", last_err, 0);
    chk(rd_status == 4'b0011, "R6 command held", rd_status, 4'b0011);
    while (!rd_status[3]) @(negedge clk);
    chk(rd_status == 4'b1011, "R6 in flight", rd_status, 4'b1011);
    while (!rd_valid) @(negedge clk);
    chk(rd_status == 4'b0101, "R7 data held", rd_status, 4'b0101);
    chk(req_seen == n0 + 1, "R3 exactly one request", req_seen, n0 + 1);
    pop_chk("R3 4-byte data");
    chk(rd_status == 0, "R7 drained", rd_status, 0);

    // 32-byte read with consumer held off
    req_tag = "R1 32-byte address";
    cfg(0, 2'd2);
    expect_rd(48'h5A5A_0000_1000, 32);
    waddr(1, 48'h5A5A_0000_1000);
    while (!rd_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rd_valid && rd_data == exp_data(48'h5A5A_0000_1000, 32), "R10 output held",
        rd_data, exp_data(48'h5A5A_0000_1000, 32));
    pop_chk("R1 32-byte data");

    // R2: low-half write keeps the upper field, gapped beats
    req_tag = "R2 low-half address";
    beat_gap = 1;
    cfg(0, 2'd3);
    expect_rd(48'h5A5A_0000_2040, 64);
    waddr(0, 48'hFFFF_0000_2040);
    pop_chk("R2 64-byte data");
    beat_gap = 0;

    // R8: rejected size settings
    cfg(0, 2'd1);
    n0 = req_seen;
    waddr(1, 48'h0000_0000_0001);
    chk(last_err, "R8 reserved size error", last_err, 1);
    @(negedge clk);
    chk(!cmd_err, "R8 error lasts one cycle", cmd_err, 0);
    repeat (10) @(negedge clk);
    chk(req_seen == n0 && rd_status == 0, "R8 reserved issues nothing", {req_seen, rd_status}, {n0, 4'h0});
    cfg(1, 2'd0);
    waddr(1, 48'h0000_0000_0040);
    chk(last_err, "R8 auto with 4 bytes error", last_err, 1);
    repeat (10) @(negedge clk);
    chk(req_seen == n0 && rd_status == 0, "R8 auto 4-byte issues nothing", {req_seen, rd_status}, {n0, 4'h0});

    // R9: writes while command or data held
    req_tag = "R9 first address";
    cfg(0, 2'd2);
    req_stall = 6;
    n0 = req_seen;
    expect_rd(48'h0000_0000_3000, 32);
    waddr(1, 48'h0000_0000_3000);
    waddr(1, 48'h0000_0000_7000);
    chk(last_err, "R9 blocked by command", last_err, 1);
    while (!rd_valid) @(negedge clk);
    waddr(1, 48'h0000_0000_9000);
    chk(last_err, "R9 blocked by data", last_err, 1);
    repeat (6) @(negedge clk);
    chk(req_seen == n0 + 1, "R9 writes dropped", req_seen, n0 + 1);
    pop_chk("R9 data intact");
    req_stall = 2;

    // R4/R5: auto 32-byte run across a 32-bit carry, then stop mid-flight
    req_tag = "R4 auto32 address";
    beat_gap = 1;
    cfg(1, 2'd2);
    expect_rd(48'h0001_FFFF_FFE0, 32);
    waddr(1, 48'h0001_FFFF_FFE0);
    for (int i = 1; i <= 3; i++) begin
      expect_rd(48'h0001_FFFF_FFE0 + 48'(32 * i), 32);
      pop_chk("R4 auto32 data");
    end
    while (!rd_status[3]) @(negedge clk);
    cfg(0, 2'd2);
    pop_chk("R5 in-flight read delivered");
    n0 = req_seen;
    repeat (30) @(negedge clk);
    chk(req_seen == n0 && rd_status == 0, "R5 no further reads", {req_seen, rd_status}, {n0, 4'h0});

    // R4/R5: auto 64-byte with low-half start
    req_tag = "R4 auto64 address";
    cfg(1, 2'd3);
    expect_rd(48'h0002_0000_0400, 64);
    waddr(0, 48'h0000_0000_0400);
    expect_rd(48'h0002_0000_0440, 64);
    pop_chk("R4 auto64 data");
    while (!rd_status[3]) @(negedge clk);
    cfg(0, 2'd3);
    pop_chk("R5 auto64 final data");
    n0 = req_seen;
    repeat (40) @(negedge clk);
    chk(req_seen == n0 && rd_status == 0, "R5 auto64 stopped", {req_seen, rd_status}, {n0, 4'h0});
    beat_gap = 0;

    // R11: stray beat on an idle bus
    stray_go = 1;
    repeat (6) @(negedge clk);
    chk(rd_status == 0 && !rd_valid, "R11 stray beat ignored", {rd_status, rd_valid}, 0);
    req_tag = "R11 follow-up address";
    cfg(0, 2'd2);
    expect_rd(48'h0000_0000_0800, 32);
    waddr(1, 48'h0000_0000_0800);
    pop_chk("R11 next read clean");
    chk(exp_req_q.size() == 0, "R3 all expected requests seen", exp_req_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule